// File: doc/BRIEF.md
# GPIO Port with Change Interrupt

This block is an 8-bit general-purpose I/O port that sits behind a serial register interface. Three write-only configuration registers set each pin's direction, the value it drives when it is an output, and whether it can raise an interrupt. Input pins are passed through a synchroniser and compared with a stored reference. A difference on a pin that is both an input and enabled sets a sticky change flag. Any set flag pulls the active-low interrupt line.

The bus interface pulses a snapshot strobe when it acknowledges a read address. On that cycle the port latches the synchronised pin values as the read data, clears every change flag, releases the interrupt, and loads the new snapshot as the comparison reference. Detection is live again on the next cycle, so a pin that moves while the read byte is still being shifted out raises the interrupt again.

While a pin's interrupt is disabled, its reference follows the pin. Enabling it later therefore does not report a change that happened before it was enabled.

Top module: `gpio_chg_port`

## Requirements
- R1: After a synchronous reset, all pins are inputs (`pad_oe` = 0x00), `pad_out` = 0x00, `int_n` = 1, `rd_data` = 0x00, and every interrupt is disabled.
- R2: A write with `wr_sel` = 0 loads the direction register. Bit value 1 makes a pin an input and 0 makes it an output. On the clock after the write, `pad_oe` equals the bitwise inverse of the written byte.
- R3: A write with `wr_sel` = 1 loads the output register. `pad_out` shows the written byte on the clock after the write.
- R4: A write with `wr_sel` = 2 loads the interrupt mask. Bit value 1 disables that pin's interrupt and 0 enables it. A change on a disabled pin never drives `int_n` low.
- R5: A pin configured as an output never causes an interrupt, whatever its mask bit.
- R6: A change on an enabled input drives `int_n` low on the third rising edge after the change: two synchroniser stages plus the flag register. It does not go low earlier.
- R7: On the edge where `snap` is high, `rd_data` takes the synchronised pin values and `int_n` returns to 1.
- R8: Change flags are sticky. If a pin returns to its reference value, `int_n` stays low until the next snapshot.
- R9: A pin change that starts in the same cycle as the snapshot, or any later cycle, sets a flag against the new reference and drives `int_n` low again.
- R10: `rd_data` holds its value between snapshots, whatever the pins do.
- R11: A pin that differed from its reference while its interrupt was disabled does not assert `int_n` when the interrupt is later enabled.
- R12: A write with `wr_sel` = 3 changes none of the direction, output or mask registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 direction, 1 output data, 2 interrupt mask |
| wr_data | input | 8 | Write data |
| snap | input | 1 | Snapshot strobe from the bus interface at read-address acknowledge |
| pad_in | input | 8 | Pin input values (asynchronous) |
| pad_oe | output | 8 | Per-pin output enable, 1 = drive |
| pad_out | output | 8 | Per-pin output data |
| rd_data | output | 8 | Snapshotted input value for the reader |
| int_n | output | 1 | Change interrupt, active low |

## Verification
The assertions check, on every cycle, the register-to-pin relations after a write, the release of `int_n` one cycle after a snapshot, the stability of `rd_data` between snapshots, and that `int_n` only falls when the port had at least one enabled input and no snapshot was taking place. Only the bench scenarios can show the following: the exact three-edge latency from a pin change to the interrupt, the sticky flag when a pin toggles back, catching a change during the read transfer, masking and output-pin filtering for particular bits, the lack of a spurious interrupt on enabling, and the ignored select code.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_OUT  = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_chg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] mask_q
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '1;
      out_q  <= '0;
      mask_q <= '1;
    end else if (wr_en) begin
      case (sel)
        SEL_DIR:  dir_q  <= wr_data;
        SEL_OUT:  out_q  <= wr_data;
        SEL_MASK: mask_q <= wr_data;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pins_s,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] mask_q,
  input  logic             snap,
  output logic [WIDTH-1:0] snap_q,
  output logic             int_n
);
  logic [WIDTH-1:0] ref_q, flag_q, en, diff, flag_nxt;

  assign en       = dir_q & ~mask_q;
  assign diff     = (pins_s ^ ref_q) & en;
  assign flag_nxt = (flag_q | diff) & en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q  <= '0;
      flag_q <= '0;
      snap_q <= '0;
      int_n  <= 1'b1;
    end else if (snap) begin
      snap_q <= pins_s;
      ref_q  <= pins_s;
      flag_q <= '0;
      int_n  <= 1'b1;
    end else begin
      flag_q <= flag_nxt;
      int_n  <= ~|flag_nxt;
      ref_q  <= (ref_q & en) | (pins_s & ~en);
    end
  end
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             snap,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] rd_data,
  output logic             int_n
);
  logic [WIDTH-1:0] dir_q, out_q, mask_q, pins_s;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pins_s)
  );

  gpio_cfg_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .dir_q(dir_q), .out_q(out_q), .mask_q(mask_q)
  );

  gpio_chg_detect #(.WIDTH(WIDTH)) u_det (
    .clk(clk), .rst(rst), .pins_s(pins_s), .dir_q(dir_q), .mask_q(mask_q),
    .snap(snap), .snap_q(rd_data), .int_n(int_n)
  );

  assign pad_oe  = ~dir_q;
  assign pad_out = out_q;
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [WIDTH-1:0] wr_data,
  input logic             snap,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] rd_data,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] mask_q,
  input logic             int_n
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (int_n && pad_oe == '0 && pad_out == '0 && rd_data == '0));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0) |=> (pad_oe == ~$past(wr_data)));

  // R3
  out_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd1) |=> (pad_out == $past(wr_data)));

  // R7
  snap_release_chk: assert property (@(posedge clk) disable iff (rst)
    snap |=> int_n);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !snap |=> $stable(rd_data));

  // R4
  fall_needs_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(int_n) |-> (($past(dir_q & ~mask_q) != '0) && !$past(snap)));
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .snap(snap), .pad_oe(pad_oe), .pad_out(pad_out), .rd_data(rd_data),
  .dir_q(dir_q), .mask_q(mask_q), .int_n(int_n)
);

// File: tb/gpio_chg_port_tb.sv
module gpio_chg_port_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic         snap = 1'b0;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_oe, pad_out, rd_data;
  logic         int_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  gpio_chg_port #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .snap(snap), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .rd_data(rd_data), .int_n(int_n)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(logic [1:0] sel, logic [W-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic do_snap();
    snap = 1'b1;
    step(1);
    snap = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; pad_in = '0;
    step(3);
    rst = 1'b0;
    step(1);
  endtask

  task automatic arm_all();
    do_reset();
    write(2'd2, 8'h00);
    step(3);
    do_snap();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 oe", pad_oe, 8'h00);
    check("R1 out", pad_out, 8'h00);
    check("R1 int_n", {7'b0, int_n}, 8'h01);
    check("R1 rd", rd_data, 8'h00);
    pad_in = 8'hFF;
    step(5);
    check("R1 masked at reset", {7'b0, int_n}, 8'h01);
  endtask

  task automatic t_regs();
    do_reset();
    write(2'd0, 8'h5A);
    check("R2 oe", pad_oe, 8'hA5);
    write(2'd1, 8'h3C);
    check("R3 out", pad_out, 8'h3C);
    check("R3 oe kept", pad_oe, 8'hA5);
  endtask

  task automatic t_latency();
    arm_all();
    pad_in = 8'h04;
    step(2);
    check("R6 not early", {7'b0, int_n}, 8'h01);
    step(1);
    check("R6 asserted", {7'b0, int_n}, 8'h00);
  endtask

  task automatic t_mask();
    do_reset();
    write(2'd2, 8'h0F);
    step(3);
    do_snap();
    pad_in = 8'h05;
    step(5);
    check("R4 masked bits", {7'b0, int_n}, 8'h01);
    pad_in = 8'h45;
    step(3);
    check("R4 enabled bit", {7'b0, int_n}, 8'h00);
  endtask

  task automatic t_output();
    arm_all();
    write(2'd0, 8'hF0);
    pad_in = 8'h0F;
    step(5);
    check("R5 output pins", {7'b0, int_n}, 8'h01);
    pad_in = 8'h1F;
    step(3);
    check("R5 input pin", {7'b0, int_n}, 8'h00);
  endtask

  task automatic t_snapshot();
    arm_all();
    pad_in = 8'h81;
    step(4);
    check("R7 pre", {7'b0, int_n}, 8'h00);
    do_snap();
    check("R7 rd", rd_data, 8'h81);
    check("R7 release", {7'b0, int_n}, 8'h01);
    pad_in = 8'h7E;
    step(5);
    check("R10 rd hold", rd_data, 8'h81);
  endtask

  task automatic t_sticky();
    arm_all();
    pad_in = 8'h10;
    step(4);
    pad_in = 8'h00;
    step(5);
    check("R8 sticky", {7'b0, int_n}, 8'h00);
    do_snap();
    step(3);
    check("R8 cleared", {7'b0, int_n}, 8'h01);
  endtask

  task automatic t_during();
    arm_all();
    pad_in = 8'h22;
    step(4);
    snap = 1'b1;
    pad_in = 8'h20;
    step(1);
    snap = 1'b0;
    check("R9 release", {7'b0, int_n}, 8'h01);
    check("R9 rd old", rd_data, 8'h22);
    step(1);
    check("R9 still high", {7'b0, int_n}, 8'h01);
    step(1);
    check("R9 reasserted", {7'b0, int_n}, 8'h00);
  endtask

  task automatic t_enable();
    do_reset();
    pad_in = 8'h01;
    step(4);
    write(2'd2, 8'h00);
    step(4);
    check("R11 no spurious", {7'b0, int_n}, 8'h01);
    pad_in = 8'h00;
    step(3);
    check("R11 live", {7'b0, int_n}, 8'h00);
  endtask

  task automatic t_badsel();
    do_reset();
    write(2'd0, 8'hC3);
    write(2'd1, 8'h99);
    write(2'd3, 8'h00);
    check("R12 oe", pad_oe, 8'h3C);
    check("R12 out", pad_out, 8'h99);
    pad_in = 8'h81;
    step(5);
    check("R12 mask kept", {7'b0, int_n}, 8'h01);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(1);
    t_reset();
    t_regs();
    t_latency();
    t_mask();
    t_output();
    t_snapshot();
    t_sticky();
    t_during();
    t_enable();
    t_badsel();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule